// File: doc/BRIEF.md
# Real-Time Tick, Base Tick and Watchdog Unit

This block keeps time for a small controller. Two tick generators count rising edges of a timebase clock. That clock is either an internal slow clock or an external clock pin, and one option bit picks it for both generators. Each generator divides the timebase by a selectable power of two. Every time its divided square wave changes level, it raises a sticky flag. A flag can drive an interrupt request when the tick's own enable and an external interrupt-enable input are both set.

The third part is a watchdog. It counts prescaled system clocks. When its counter wraps, it sets a flag and sends a one-cycle warm-reset request to the surrounding chip. Once software starts the watchdog, it runs until power-on reset. Writing its enable bit low only restarts the count. Software uses two write-only registers, selected by a one-bit address. The timebase inputs are asynchronous and are synchronised inside the block.

Top module: `tick_wdog_unit`

## Requirements
- R1: After power-on reset, all three flags, both interrupt requests and the reset request are 0, and the watchdog is idle and produces no request.
- R2: The clock-option register (address 0) holds bit 0 = timebase source (1 external pin, 0 internal clock), bits 2:1 = real-time divide code, bits 4:3 = base divide code.
- R3: The control register (address 1) holds bit 0 real-time flag, bit 1 real-time enable, bit 2 base flag, bit 3 base enable, bit 4 watchdog flag, bit 5 watchdog enable, bits 7:6 watchdog divide code. Writing 0 to a flag bit clears that flag. Writing 1 leaves it unchanged.
- R4: With real-time code s (0..3), the tick divides the timebase by 32<<s. Its flag sets every 16<<s timebase rising edges counted from enable. While disabled, its count is held at zero and its flag is never set.
- R5: With base code s, the tick divides by 2<<s, and its flag sets every 1<<s rising edges counted from enable. The same rules apply while it is disabled.
- R6: Only rising edges of the source chosen by the option bit advance the tick counters.
- R7: A tick's interrupt request is 1 exactly while its flag, its enable bit and its interrupt-enable input are all 1.
- R8: If a flag set and a software clear of that flag land in the same cycle, the flag ends up set.
- R9: Writing 1 to the watchdog enable starts it. With divide code d, the first overflow comes (2<<d)·2^W system clocks after the enabling write, where W is the counter width (default 16).
- R10: While the watchdog runs, writing its enable bit as 0 does not stop it. The write zeroes the count, and the next overflow comes one full period after that write.
- R11: On each overflow, the watchdog flag is set and the reset request is high for exactly one cycle. Counting goes on, and the next overflow comes one period later.
- R12: The watchdog flag stays set until software clears it or power-on reset occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the clock-option register, 1 selects the control register |
| reg_wdata | input | 8 | Register write data |
| tb_int_clk | input | 1 | Internal timebase clock, asynchronous |
| tb_ext_clk | input | 1 | External timebase clock pin, asynchronous |
| rt_ie | input | 1 | Real-time interrupt enable |
| bt_ie | input | 1 | Base tick interrupt enable |
| rt_flag | output | 1 | Real-time tick flag |
| bt_flag | output | 1 | Base tick flag |
| wd_flag | output | 1 | Watchdog overflow flag |
| rt_irq | output | 1 | Real-time interrupt request |
| bt_irq | output | 1 | Base tick interrupt request |
| wd_rst_req | output | 1 | Warm-reset request pulse |

## Verification
The bench counts timebase edges up to one short of each toggle and then exactly to the toggle. A divider that is off by one, or that sets the flag on only one level change, is caught there. It also switches the source and pulses the source that is not selected, which catches a wrong mux. It lines up a software clear with a hardware set in the same cycle to catch a clear that wins. On the watchdog, it checks the request in the cycle before and after each expected overflow. It confirms that a low enable write restarts the period without stopping the count. A design that stopped, failed to restart, or used the wrong prescale would put the request in the wrong cycle or never raise it.

// File: rtl/twu_pkg.sv
package twu_pkg;
  typedef enum logic {REG_CLKOPT = 1'b0, REG_TMRCTL = 1'b1} reg_sel_e;

  localparam int SEL_W = 2;

  localparam int CTL_RT_FLAG   = 0;
  localparam int CTL_RT_EN     = 1;
  localparam int CTL_BT_FLAG   = 2;
  localparam int CTL_BT_EN     = 3;
  localparam int CTL_WD_FLAG   = 4;
  localparam int CTL_WD_EN     = 5;
  localparam int CTL_WD_DIV_LO = 6;

  typedef struct packed {
    logic [SEL_W-1:0] bt_sel;
    logic [SEL_W-1:0] rt_sel;
    logic             src_ext;
  } clkopt_t;
endpackage

// File: rtl/twu_sync.sv
module twu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q, ff_d;

  always_comb begin
    ff_d = {ff_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= ff_d;
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/twu_tick_div.sv
module twu_tick_div #(
  parameter int BASE_LOG = 5
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    en,
  input  logic                    step,
  input  logic [twu_pkg::SEL_W-1:0] sel,
  input  logic                    clr,
  output logic                    flag
);
  localparam int CW = BASE_LOG + (1 << twu_pkg::SEL_W) - 1;

  logic [CW-1:0] cnt_q, cnt_d, mask;
  logic          flag_q, flag_d, hit;

  always_comb begin
    for (int i = 0; i < CW; i++) mask[i] = (i < BASE_LOG - 1 + int'(sel));
    hit    = en && step && ((cnt_q & mask) == mask);
    cnt_d  = cnt_q;
    if (!en)       cnt_d = '0;
    else if (step) cnt_d = cnt_q + CW'(1);
    flag_d = flag_q;
    if (hit)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  // R4 (and R5 for the base instance): a flag rises only on a counted edge
  a_r4_flag_rise_on_step: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(en && step));
  // R4/R5: a disabled tick never sets its flag
  a_r4_no_set_while_off: assert property (@(posedge clk) disable iff (!rst_ni)
    (!en && !flag_q) |=> !flag_q);
endmodule

// File: rtl/twu_watchdog.sv
module twu_watchdog #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             start,
  input  logic             kick,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             flag,
  output logic             rst_req
);
  localparam int PRE_W = 1 << DIV_W;

  logic             run_q, run_d;
  logic [PRE_W-1:0] pre_q, pre_d, pmask;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d, req_q, req_d;
  logic             restart, strobe, ovf;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) pmask[i] = (i <= int'(div));
    restart = (start && !run_q) || (kick && run_q);
    strobe  = run_q && !restart && ((pre_q & pmask) == pmask);
    ovf     = strobe && (&cnt_q);
    run_d   = run_q || start;
    pre_d   = pre_q;
    cnt_d   = cnt_q;
    if (restart) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (run_q) begin
      pre_d = pre_q + PRE_W'(1);
      if (strobe) cnt_d = cnt_q + CNT_W'(1);
    end
    flag_d = flag_q;
    if (ovf)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    req_d = ovf;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      pre_q  <= '0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      pre_q  <= pre_d;
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
      req_q  <= req_d;
    end
  end

  assign flag    = flag_q;
  assign rst_req = req_q;

  a_r11_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_ni)
    req_q |=> !req_q);
  a_r11_req_with_flag: assert property (@(posedge clk) disable iff (!rst_ni)
    req_q |-> flag_q);
  a_r10_never_stops: assert property (@(posedge clk) disable iff (!rst_ni)
    run_q |=> run_q);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    !run_q |-> (cnt_q == '0) && !req_q && !flag_q);
endmodule

// File: rtl/tick_wdog_unit.sv
module tick_wdog_unit #(
  parameter int RT_BASE_LOG = 5,
  parameter int BT_BASE_LOG = 1,
  parameter int WD_CNT_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       tb_int_clk,
  input  logic       tb_ext_clk,
  input  logic       rt_ie,
  input  logic       bt_ie,
  output logic       rt_flag,
  output logic       bt_flag,
  output logic       wd_flag,
  output logic       rt_irq,
  output logic       bt_irq,
  output logic       wd_rst_req
);
  import twu_pkg::*;

  localparam int NSRC = 2;

  logic            rst_sync_n;
  logic [NSRC-1:0] src_raw, src_sync;
  clkopt_t         opt_q, opt_d;
  logic            rt_en_q, rt_en_d, bt_en_q, bt_en_d;
  logic [1:0]      wd_div_q, wd_div_d;
  logic            tb_prev_q, tb_sel, tb_step;
  logic            opt_wr, ctl_wr;

  twu_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_ni(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  assign src_raw = {tb_ext_clk, tb_int_clk};

  for (genvar g = 0; g < NSRC; g++) begin : g_src_sync
    twu_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_ni(rst_sync_n), .d(src_raw[g]), .q(src_sync[g])
    );
  end

  always_comb begin
    opt_wr   = reg_wr && (reg_addr == REG_CLKOPT);
    ctl_wr   = reg_wr && (reg_addr == REG_TMRCTL);
    opt_d    = opt_q;
    rt_en_d  = rt_en_q;
    bt_en_d  = bt_en_q;
    wd_div_d = wd_div_q;
    if (opt_wr) opt_d = clkopt_t'(reg_wdata[4:0]);
    if (ctl_wr) begin
      rt_en_d  = reg_wdata[CTL_RT_EN];
      bt_en_d  = reg_wdata[CTL_BT_EN];
      wd_div_d = reg_wdata[CTL_WD_DIV_LO +: 2];
    end
    tb_sel  = opt_q.src_ext ? src_sync[1] : src_sync[0];
    tb_step = tb_sel && !tb_prev_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      opt_q     <= '0;
      rt_en_q   <= 1'b0;
      bt_en_q   <= 1'b0;
      wd_div_q  <= '0;
      tb_prev_q <= 1'b0;
    end else begin
      opt_q     <= opt_d;
      rt_en_q   <= rt_en_d;
      bt_en_q   <= bt_en_d;
      wd_div_q  <= wd_div_d;
      tb_prev_q <= tb_sel;
    end
  end

  twu_tick_div #(.BASE_LOG(RT_BASE_LOG)) u_rt_div (
    .clk(clk), .rst_ni(rst_sync_n), .en(rt_en_q), .step(tb_step),
    .sel(opt_q.rt_sel), .clr(ctl_wr && !reg_wdata[CTL_RT_FLAG]), .flag(rt_flag)
  );

  twu_tick_div #(.BASE_LOG(BT_BASE_LOG)) u_bt_div (
    .clk(clk), .rst_ni(rst_sync_n), .en(bt_en_q), .step(tb_step),
    .sel(opt_q.bt_sel), .clr(ctl_wr && !reg_wdata[CTL_BT_FLAG]), .flag(bt_flag)
  );

  twu_watchdog #(.CNT_W(WD_CNT_W), .DIV_W(2)) u_wdog (
    .clk(clk), .rst_ni(rst_sync_n),
    .start(ctl_wr && reg_wdata[CTL_WD_EN]),
    .kick(ctl_wr && !reg_wdata[CTL_WD_EN]),
    .clr(ctl_wr && !reg_wdata[CTL_WD_FLAG]),
    .div(wd_div_q), .flag(wd_flag), .rst_req(wd_rst_req)
  );

  assign rt_irq = rt_flag && rt_en_q && rt_ie;
  assign bt_irq = bt_flag && bt_en_q && bt_ie;

  // R6: a counted timebase step needs the selected source to be high
  a_r6_step_needs_level: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tb_step |=> tb_prev_q);
endmodule

// File: tb/tick_wdog_unit_bench.sv
module tick_wdog_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_W       = 6;
  localparam int MAX_CYC    = 20000;
  localparam int S_RT = 0, S_BT = 1, S_WD = 2, S_RTI = 3, S_BTI = 4, S_REQ = 5;

  typedef struct {
    int    at;
    int    sig;
    logic  exp;
    string tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic tb_int_clk = 1'b0, tb_ext_clk = 1'b0, rt_ie = 1'b1, bt_ie = 1'b1;
  logic rt_flag, bt_flag, wd_flag, rt_irq, bt_irq, wd_rst_req;
  int   cyc = 0, n_chk = 0, n_bad = 0;
  bit   done = 1'b0;
  item_t q[$];

  tick_wdog_unit #(.WD_CNT_W(WD_W)) u_tick_wdog_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tb_int_clk(tb_int_clk), .tb_ext_clk(tb_ext_clk),
    .rt_ie(rt_ie), .bt_ie(bt_ie), .rt_flag(rt_flag), .bt_flag(bt_flag),
    .wd_flag(wd_flag), .rt_irq(rt_irq), .bt_irq(bt_irq), .wd_rst_req(wd_rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic observe(input int s);
    case (s)
      S_RT:    return rt_flag;
      S_BT:    return bt_flag;
      S_WD:    return wd_flag;
      S_RTI:   return rt_irq;
      S_BTI:   return bt_irq;
      default: return wd_rst_req;
    endcase
  endfunction

  // monitor: pops expectations whose cycle has come
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].at <= cyc) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (observe(it.sig) !== it.exp) begin
          n_bad++;
          $display("FAIL %s sig %0d cycle %0d actual %b expected %b",
                   it.tag, it.sig, cyc, observe(it.sig), it.exp);
        end
      end
    end
  end

  task automatic expect_at(input int s, input logic e, input string tag, input int at);
    item_t it;
    it.at = at; it.sig = s; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic chk(input int s, input logic e, input string tag);
    expect_at(s, e, tag, cyc + 1);
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input bit ext, input int n);
    for (int i = 0; i < n; i++) begin
      if (ext) tb_ext_clk = 1'b1; else tb_int_clk = 1'b1;
      repeat (4) @(negedge clk);
      if (ext) tb_ext_clk = 1'b0; else tb_int_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d actual running expected finished", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int wedge, k, k2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(S_RT, 1'b0, "R1"); chk(S_BT, 1'b0, "R1"); chk(S_WD, 1'b0, "R1");
    chk(S_RTI, 1'b0, "R1"); chk(S_BTI, 1'b0, "R1"); chk(S_REQ, 1'b0, "R1");

    // R2/R4: internal source, real-time code 0, flag every 16 edges
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h02);
    pulse(1'b0, 15);
    chk(S_RT, 1'b0, "R4"); chk(S_RTI, 1'b0, "R7");
    pulse(1'b0, 1);
    chk(S_RT, 1'b1, "R4"); chk(S_RTI, 1'b1, "R7");
    chk(S_BT, 1'b0, "R5");
    // R3: flag bit written as 1 keeps, written as 0 clears
    wr(1'b1, 8'h03);
    chk(S_RT, 1'b1, "R3");
    wr(1'b1, 8'h02);
    chk(S_RT, 1'b0, "R3"); chk(S_RTI, 1'b0, "R7");
    pulse(1'b0, 15);
    chk(S_RT, 1'b0, "R4");
    pulse(1'b0, 1);
    chk(S_RT, 1'b1, "R4");
    rt_ie = 1'b0;
    @(negedge clk);
    chk(S_RTI, 1'b0, "R7");

    // R4 code 1: every 32 edges from a fresh enable
    wr(1'b1, 8'h00);
    chk(S_RT, 1'b0, "R3");
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h02);
    pulse(1'b0, 31);
    chk(S_RT, 1'b0, "R4");
    pulse(1'b0, 1);
    chk(S_RT, 1'b1, "R4");

    // R5 base code 2: every 4 edges
    wr(1'b1, 8'h08);
    wr(1'b0, 8'h10);
    pulse(1'b0, 3);
    chk(S_BT, 1'b0, "R5"); chk(S_RT, 1'b0, "R4");
    pulse(1'b0, 1);
    chk(S_BT, 1'b1, "R5"); chk(S_BTI, 1'b1, "R7");
    // R5 code 0: every edge
    wr(1'b1, 8'h08);
    wr(1'b0, 8'h00);
    chk(S_BT, 1'b0, "R5");
    pulse(1'b0, 1);
    chk(S_BT, 1'b1, "R5");

    // R6: external source selected, internal edges ignored
    wr(1'b1, 8'h08);
    wr(1'b0, 8'h01);
    pulse(1'b0, 3);
    chk(S_BT, 1'b0, "R6");
    pulse(1'b1, 1);
    chk(S_BT, 1'b1, "R6");

    // R8: hardware set and software clear in the same edge
    wr(1'b1, 8'h08);
    chk(S_BT, 1'b0, "R8");
    tb_ext_clk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(1'b1, 8'h08);
    chk(S_BT, 1'b1, "R8");
    tb_ext_clk = 1'b0;
    repeat (4) @(negedge clk);

    // R9/R11/R12: watchdog code 0, period 2*2^W
    chk(S_WD, 1'b0, "R9"); chk(S_REQ, 1'b0, "R9");
    wr(1'b1, 8'h20);
    wedge = cyc;
    expect_at(S_WD, 1'b0, "R9", wedge + 127);
    expect_at(S_REQ, 1'b0, "R9", wedge + 127);
    expect_at(S_REQ, 1'b1, "R9", wedge + 128);
    expect_at(S_WD, 1'b1, "R11", wedge + 128);
    expect_at(S_REQ, 1'b0, "R11", wedge + 129);
    expect_at(S_WD, 1'b1, "R12", wedge + 150);
    wait_until(wedge + 150);
    wr(1'b1, 8'h20);
    chk(S_WD, 1'b0, "R12");
    expect_at(S_REQ, 1'b0, "R11", wedge + 255);
    expect_at(S_REQ, 1'b1, "R11", wedge + 256);
    expect_at(S_WD, 1'b1, "R11", wedge + 256);
    wait_until(wedge + 300);

    // R10: enable written low restarts the count and does not stop it
    wr(1'b1, 8'h00);
    k = cyc;
    expect_at(S_REQ, 1'b0, "R10", wedge + 384);
    expect_at(S_WD, 1'b0, "R10", k + 127);
    expect_at(S_REQ, 1'b1, "R10", k + 128);
    wait_until(k + 140);

    // R9 divide code 1: period 4*2^W
    wr(1'b1, 8'h40);
    k2 = cyc;
    expect_at(S_REQ, 1'b0, "R9", k2 + 128);
    expect_at(S_REQ, 1'b1, "R9", k2 + 256);
    wait_until(k2 + 260);

    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule